// File: doc/BRIEF.md
# DMA Channel Control Register File

This block is the software-visible register file of a multi-channel DMA layer. It decodes a 10-bit control-register address bus with single-cycle read and write strobes and 32-bit data. It holds a global configuration word, an error status word and an interrupt enable field. Per direction, it holds a pair of channel-activation words, one to request activation and one to request deactivation. It also holds per-channel end-of-buffer and descriptor-error interrupt flags, per-channel descriptor table pointers and per-channel receive buffer sizes.

Every stored value is driven straight out to the DMA engine. The engine raises status flags through one-cycle set pulses, and software acknowledges them by writing ones. A configuration write with its top bit set reinitialises the control and status state before the new configuration is loaded. The transmit and receive channel counts are parameters, each between 1 and 32. The per-channel address windows only respond below those counts.

Top module: `dma_ctl_regs`

## Requirements
- R1: After reset the configuration word reads 0x0007C000. The error status, interrupt enable, both activate words, both deactivate words, all channel flags, pointers, sizes and the read data output are zero.
- R2: A write to address 0x180 stores the written data ANDed with 0x00FFC087, so bit 31 never stays set.
- R3: A write to 0x180 with bit 31 set first returns the error status, interrupt enable, both activate words and the four flag registers to their reset values. The deactivate words, pointers and sizes keep their contents.
- R4: The interrupt enable at 0x182 keeps bits 4:0. The transmit activate and deactivate words at 0x184 and 0x185 keep bits 31:28. The receive activate and deactivate words at 0x190 and 0x191 keep bits 31:30.
- R5: Error status (0x181), transmit end-of-buffer (0x186), transmit descriptor-error (0x187), receive end-of-buffer (0x192) and receive descriptor-error (0x193) are write-one-to-clear. A 1 clears the stored bit and a 0 leaves it unchanged.
- R6: A set pulse on a flag input sets the matching bit. For channel flags, channel i is bit i. When a set pulse meets a clearing write or the bit-31 reinitialisation in the same cycle, the bit ends up set.
- R7: Transmit descriptor pointer i is at 0x1A0+i and receive descriptor pointer i is at 0x1C0+i, each holding 32 bits. Receive buffer size i is at 0x1E0+i and keeps bits 7:0.
- R8: Window addresses at or beyond the channel count are not decoded. Writes there change no output, and reads there return zero.
- R9: A read of any address that is not decoded returns zero.
- R10: Read data is registered. It presents the value held before the strobe edge one cycle after the read strobe, and it holds until the next read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 10 | Register address |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| esr_set_i | input | 32 | Error status set pulses |
| tx_eob_set_i | input | NTX | Transmit end-of-buffer set pulses |
| tx_derr_set_i | input | NTX | Transmit descriptor-error set pulses |
| rx_eob_set_i | input | NRX | Receive end-of-buffer set pulses |
| rx_derr_set_i | input | NRX | Receive descriptor-error set pulses |
| cfg_o | output | 32 | Configuration word |
| esr_o | output | 32 | Error status word |
| ier_o | output | 5 | Interrupt enable field |
| tx_act_set_o | output | 32 | Transmit activate word |
| tx_act_rst_o | output | 32 | Transmit deactivate word |
| rx_act_set_o | output | 32 | Receive activate word |
| rx_act_rst_o | output | 32 | Receive deactivate word |
| tx_eob_o | output | NTX | Transmit end-of-buffer flags |
| tx_derr_o | output | NTX | Transmit descriptor-error flags |
| rx_eob_o | output | NRX | Receive end-of-buffer flags |
| rx_derr_o | output | NRX | Receive descriptor-error flags |
| tx_desc_ptr_o | output | NTX*32 | Transmit descriptor pointers, channel i at bits 32i+31:32i |
| rx_desc_ptr_o | output | NRX*32 | Receive descriptor pointers, channel i at bits 32i+31:32i |
| rx_buf_size_o | output | NRX*8 | Receive buffer sizes, channel i at bits 8i+7:8i |

## Verification
The assertions assume that reset is held low across at least one clock edge. They also assume that the strobes and set pulses are clean levels sampled at the rising edge. No assumption is made about read and write coinciding, because each property only looks at one strobe. The stimulus changes every input on the falling edge and asserts at most one strobe per cycle, so the registered read value always comes from a state that no write in the same cycle has altered. Set pulses are deliberately lined up with clearing writes and with the bit-31 reinitialisation, so that the priority rule is exercised.

// File: rtl/dmareg_pkg.sv
package dmareg_pkg;

  localparam int AW = 10;
  localparam int DW = 32;

  localparam logic [AW-1:0] A_CFG     = 10'h180;
  localparam logic [AW-1:0] A_ESR     = 10'h181;
  localparam logic [AW-1:0] A_IER     = 10'h182;
  localparam logic [AW-1:0] A_TX_ACT  = 10'h184;
  localparam logic [AW-1:0] A_TX_DEACT= 10'h185;
  localparam logic [AW-1:0] A_TX_EOB  = 10'h186;
  localparam logic [AW-1:0] A_TX_DERR = 10'h187;
  localparam logic [AW-1:0] A_RX_ACT  = 10'h190;
  localparam logic [AW-1:0] A_RX_DEACT= 10'h191;
  localparam logic [AW-1:0] A_RX_EOB  = 10'h192;
  localparam logic [AW-1:0] A_RX_DERR = 10'h193;
  localparam logic [AW-1:0] B_TX_PTR  = 10'h1A0;
  localparam logic [AW-1:0] B_RX_PTR  = 10'h1C0;
  localparam logic [AW-1:0] B_RX_SIZE = 10'h1E0;

  localparam logic [DW-1:0] CFG_RESET = 32'h0007_C000;
  localparam logic [DW-1:0] CFG_KEEP  = 32'h00FF_C087;
  localparam int            IER_W     = 5;
  localparam logic [DW-1:0] TX_KEEP   = 32'hF000_0000;
  localparam logic [DW-1:0] RX_KEEP   = 32'hC000_0000;
  localparam int            SIZE_W    = 8;
  localparam int            SOFT_BIT  = 31;

  // true when addr falls in [base, base+n)
  function automatic logic in_win(input logic [AW-1:0] addr,
                                  input logic [AW-1:0] base, input int n);
    int a;
    int b;
    a = int'(addr);
    b = int'(base);
    return (a >= b) && (a < b + n);
  endfunction

  function automatic logic [4:0] win_idx(input logic [AW-1:0] addr,
                                         input logic [AW-1:0] base);
    logic [AW-1:0] d;
    d = addr - base;
    return d[4:0];
  endfunction

  // stored value after an acknowledging write and set pulses; set dominates
  function automatic logic [DW-1:0] w1c_next(input logic [DW-1:0] cur,
                                             input logic wipe, input logic ack,
                                             input logic [DW-1:0] ones,
                                             input logic [DW-1:0] setv);
    logic [DW-1:0] base;
    base = wipe ? '0 : (ack ? (cur & ~ones) : cur);
    return base | setv;
  endfunction

endpackage

// File: rtl/dmareg_w1c.sv
module dmareg_w1c #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wipe,
  input  logic         ack,
  input  logic [W-1:0] ones,
  input  logic [W-1:0] setv,
  output logic [W-1:0] q
);
  import dmareg_pkg::*;

  logic [DW-1:0] nxt;
  assign nxt = w1c_next(DW'(q), wipe, ack, DW'(ones), DW'(setv));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= nxt[W-1:0];
  end

  // R6: a pulsed bit is present on the next cycle whatever else happened
  a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|setv) |=> ((q & $past(setv)) == $past(setv)));

  // R5: an acknowledged bit with no set pulse reads back clear
  a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> ((q & $past(ones) & ~$past(setv)) == '0));

  // R3: reinitialisation leaves only freshly pulsed bits
  a_r3_wipe: assert property (@(posedge clk) disable iff (!rst_n)
    wipe |=> ((q & ~$past(setv)) == '0));
endmodule

// File: rtl/dmareg_bank.sv
module dmareg_bank #(
  parameter int N  = 4,
  parameter int BW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [4:0]    wr_idx,
  input  logic [BW-1:0] wdata,
  input  logic [4:0]    rd_idx,
  output logic [BW-1:0] rd_val,
  output logic [N*BW-1:0] q_flat
);
  logic [BW-1:0] ent [N];

  for (genvar i = 0; i < N; i++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          ent[i] <= '0;
      else if (wr_en && (wr_idx == 5'(i))) ent[i] <= wdata;
    end
    assign q_flat[i*BW +: BW] = ent[i];
  end

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < N; i++)
      if (rd_idx == 5'(i)) rd_val = ent[i];
  end
endmodule

// File: rtl/dma_ctl_regs.sv
module dma_ctl_regs #(
  parameter int NTX = 4,   // 1..32
  parameter int NRX = 2    // 1..32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [9:0]      bus_addr,
  input  logic            bus_rd,
  input  logic            bus_wr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  input  logic [31:0]     esr_set_i,
  input  logic [NTX-1:0]  tx_eob_set_i,
  input  logic [NTX-1:0]  tx_derr_set_i,
  input  logic [NRX-1:0]  rx_eob_set_i,
  input  logic [NRX-1:0]  rx_derr_set_i,
  output logic [31:0]     cfg_o,
  output logic [31:0]     esr_o,
  output logic [4:0]      ier_o,
  output logic [31:0]     tx_act_set_o,
  output logic [31:0]     tx_act_rst_o,
  output logic [31:0]     rx_act_set_o,
  output logic [31:0]     rx_act_rst_o,
  output logic [NTX-1:0]  tx_eob_o,
  output logic [NTX-1:0]  tx_derr_o,
  output logic [NRX-1:0]  rx_eob_o,
  output logic [NRX-1:0]  rx_derr_o,
  output logic [NTX*32-1:0] tx_desc_ptr_o,
  output logic [NRX*32-1:0] rx_desc_ptr_o,
  output logic [NRX*8-1:0]  rx_buf_size_o
);
  import dmareg_pkg::*;

  if (NTX < 1 || NTX > 32 || NRX < 1 || NRX > 32) begin : g_bad_count
    $error("channel counts must lie in 1..32");
  end

  // ---- decode ----
  logic hit_cfg, hit_esr, hit_ier, hit_txa, hit_txd, hit_teob, hit_tder;
  logic hit_rxa, hit_rxd, hit_reob, hit_rder, hit_txp, hit_rxp, hit_rsz;
  logic rd_hit, wr_hit, soft_rst;

  assign hit_cfg  = (bus_addr == A_CFG);
  assign hit_esr  = (bus_addr == A_ESR);
  assign hit_ier  = (bus_addr == A_IER);
  assign hit_txa  = (bus_addr == A_TX_ACT);
  assign hit_txd  = (bus_addr == A_TX_DEACT);
  assign hit_teob = (bus_addr == A_TX_EOB);
  assign hit_tder = (bus_addr == A_TX_DERR);
  assign hit_rxa  = (bus_addr == A_RX_ACT);
  assign hit_rxd  = (bus_addr == A_RX_DEACT);
  assign hit_reob = (bus_addr == A_RX_EOB);
  assign hit_rder = (bus_addr == A_RX_DERR);
  assign hit_txp  = in_win(bus_addr, B_TX_PTR, NTX);
  assign hit_rxp  = in_win(bus_addr, B_RX_PTR, NRX);
  assign hit_rsz  = in_win(bus_addr, B_RX_SIZE, NRX);

  assign rd_hit = hit_cfg | hit_esr | hit_ier | hit_txa | hit_txd | hit_teob |
                  hit_tder | hit_rxa | hit_rxd | hit_reob | hit_rder |
                  hit_txp | hit_rxp | hit_rsz;
  assign wr_hit = bus_wr & rd_hit;
  assign soft_rst = bus_wr & hit_cfg & bus_wdata[SOFT_BIT];

  // ---- plain masked registers ----
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_o        <= CFG_RESET;
      ier_o        <= '0;
      tx_act_set_o <= '0;
      tx_act_rst_o <= '0;
      rx_act_set_o <= '0;
      rx_act_rst_o <= '0;
    end else begin
      if (bus_wr && hit_cfg) cfg_o <= bus_wdata & CFG_KEEP;
      if (soft_rst) begin
        ier_o        <= '0;
        tx_act_set_o <= '0;
        rx_act_set_o <= '0;
      end else begin
        if (bus_wr && hit_ier) ier_o        <= bus_wdata[IER_W-1:0];
        if (bus_wr && hit_txa) tx_act_set_o <= bus_wdata & TX_KEEP;
        if (bus_wr && hit_rxa) rx_act_set_o <= bus_wdata & RX_KEEP;
      end
      if (bus_wr && hit_txd) tx_act_rst_o <= bus_wdata & TX_KEEP;
      if (bus_wr && hit_rxd) rx_act_rst_o <= bus_wdata & RX_KEEP;
    end
  end

  // ---- acknowledge-by-one flag registers ----
  dmareg_w1c #(.W(32)) u_esr (
    .clk(clk), .rst_n(rst_n), .wipe(soft_rst), .ack(bus_wr & hit_esr),
    .ones(bus_wdata), .setv(esr_set_i), .q(esr_o));
  dmareg_w1c #(.W(NTX)) u_teob (
    .clk(clk), .rst_n(rst_n), .wipe(soft_rst), .ack(bus_wr & hit_teob),
    .ones(bus_wdata[NTX-1:0]), .setv(tx_eob_set_i), .q(tx_eob_o));
  dmareg_w1c #(.W(NTX)) u_tder (
    .clk(clk), .rst_n(rst_n), .wipe(soft_rst), .ack(bus_wr & hit_tder),
    .ones(bus_wdata[NTX-1:0]), .setv(tx_derr_set_i), .q(tx_derr_o));
  dmareg_w1c #(.W(NRX)) u_reob (
    .clk(clk), .rst_n(rst_n), .wipe(soft_rst), .ack(bus_wr & hit_reob),
    .ones(bus_wdata[NRX-1:0]), .setv(rx_eob_set_i), .q(rx_eob_o));
  dmareg_w1c #(.W(NRX)) u_rder (
    .clk(clk), .rst_n(rst_n), .wipe(soft_rst), .ack(bus_wr & hit_rder),
    .ones(bus_wdata[NRX-1:0]), .setv(rx_derr_set_i), .q(rx_derr_o));

  // ---- per-channel windows ----
  logic [31:0]       txp_rd, rxp_rd;
  logic [SIZE_W-1:0] rsz_rd;

  dmareg_bank #(.N(NTX), .BW(32)) u_txp (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr & hit_txp),
    .wr_idx(win_idx(bus_addr, B_TX_PTR)), .wdata(bus_wdata),
    .rd_idx(win_idx(bus_addr, B_TX_PTR)), .rd_val(txp_rd), .q_flat(tx_desc_ptr_o));
  dmareg_bank #(.N(NRX), .BW(32)) u_rxp (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr & hit_rxp),
    .wr_idx(win_idx(bus_addr, B_RX_PTR)), .wdata(bus_wdata),
    .rd_idx(win_idx(bus_addr, B_RX_PTR)), .rd_val(rxp_rd), .q_flat(rx_desc_ptr_o));
  dmareg_bank #(.N(NRX), .BW(SIZE_W)) u_rsz (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr & hit_rsz),
    .wr_idx(win_idx(bus_addr, B_RX_SIZE)), .wdata(bus_wdata[SIZE_W-1:0]),
    .rd_idx(win_idx(bus_addr, B_RX_SIZE)), .rd_val(rsz_rd), .q_flat(rx_buf_size_o));

  // ---- read path ----
  logic [31:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (hit_cfg)  rd_mux = cfg_o;
    if (hit_esr)  rd_mux = esr_o;
    if (hit_ier)  rd_mux = 32'(ier_o);
    if (hit_txa)  rd_mux = tx_act_set_o;
    if (hit_txd)  rd_mux = tx_act_rst_o;
    if (hit_teob) rd_mux = 32'(tx_eob_o);
    if (hit_tder) rd_mux = 32'(tx_derr_o);
    if (hit_rxa)  rd_mux = rx_act_set_o;
    if (hit_rxd)  rd_mux = rx_act_rst_o;
    if (hit_reob) rd_mux = 32'(rx_eob_o);
    if (hit_rder) rd_mux = 32'(rx_derr_o);
    if (hit_txp)  rd_mux = txp_rd;
    if (hit_rxp)  rd_mux = rxp_rd;
    if (hit_rsz)  rd_mux = 32'(rsz_rd);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  // R9: undecoded reads return zero
  a_r9_undecoded_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !rd_hit) |=> (bus_rdata == '0));

  // R10: read data only moves on a read strobe
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));

  // R8: a write outside every window leaves all channel storage alone
  a_r8_no_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !wr_hit) |=> ($stable(tx_desc_ptr_o) && $stable(rx_desc_ptr_o)
                             && $stable(rx_buf_size_o)));

  // R3: reinitialisation clears the enable field and both activate words
  a_r3_soft_clears: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (ier_o == '0 && tx_act_set_o == '0 && rx_act_set_o == '0));

  // R2: the configuration top bit never remains stored
  a_r2_cfg_top_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && hit_cfg) |=> !cfg_o[31]);
endmodule

// File: tb/dma_ctl_regs_tb.sv
module dma_ctl_regs_tb_top;
  localparam int NTX = 4;
  localparam int NRX = 2;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [9:0] bus_addr = '0;
  logic bus_rd = 1'b0, bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] esr_set_i = '0;
  logic [NTX-1:0] tx_eob_set_i = '0, tx_derr_set_i = '0;
  logic [NRX-1:0] rx_eob_set_i = '0, rx_derr_set_i = '0;
  logic [31:0] cfg_o, esr_o, tx_act_set_o, tx_act_rst_o, rx_act_set_o, rx_act_rst_o;
  logic [4:0] ier_o;
  logic [NTX-1:0] tx_eob_o, tx_derr_o;
  logic [NRX-1:0] rx_eob_o, rx_derr_o;
  logic [NTX*32-1:0] tx_desc_ptr_o;
  logic [NRX*32-1:0] rx_desc_ptr_o;
  logic [NRX*8-1:0] rx_buf_size_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_ctl_regs #(.NTX(NTX), .NRX(NRX)) dut_i (.*);

  int checks = 0, failures = 0, cycles = 0;
  bit done = 0;

  // ---- behavioural reference ----
  logic [31:0] m_cfg = 32'h0007C000, m_esr = 0, m_ier = 0, m_txa = 0, m_txd = 0;
  logic [31:0] m_rxa = 0, m_rxd = 0, m_teob = 0, m_tder = 0, m_reob = 0, m_rder = 0;
  logic [31:0] m_rdata = 0;
  logic [31:0] m_txp [NTX];
  logic [31:0] m_rxp [NRX];
  logic [31:0] m_rsz [NRX];

  function automatic logic [31:0] m_read(input int a);
    if (a >= 'h1A0 && a < 'h1A0 + NTX) return m_txp[a - 'h1A0];
    if (a >= 'h1C0 && a < 'h1C0 + NRX) return m_rxp[a - 'h1C0];
    if (a >= 'h1E0 && a < 'h1E0 + NRX) return m_rsz[a - 'h1E0];
    case (a)
      'h180: return m_cfg;  'h181: return m_esr;  'h182: return m_ier;
      'h184: return m_txa;  'h185: return m_txd;  'h186: return m_teob;
      'h187: return m_tder; 'h190: return m_rxa;  'h191: return m_rxd;
      'h192: return m_reob; 'h193: return m_rder;
      default: return 32'h0;
    endcase
  endfunction

  task automatic m_write(input int a, input logic [31:0] d);
    if (a >= 'h1A0 && a < 'h1A0 + NTX) m_txp[a - 'h1A0] = d;
    if (a >= 'h1C0 && a < 'h1C0 + NRX) m_rxp[a - 'h1C0] = d;
    if (a >= 'h1E0 && a < 'h1E0 + NRX) m_rsz[a - 'h1E0] = d % 256;
    case (a)
      'h180: begin
        if (d[31]) begin
          m_esr = 0; m_ier = 0; m_txa = 0; m_rxa = 0;
          m_teob = 0; m_tder = 0; m_reob = 0; m_rder = 0;
        end
        m_cfg = d & 32'h00FFC087;
      end
      'h181: m_esr  = m_esr  & ~d;
      'h182: m_ier  = d % 32;
      'h184: m_txa  = d & 32'hF0000000;
      'h185: m_txd  = d & 32'hF0000000;
      'h186: m_teob = m_teob & ~d;
      'h187: m_tder = m_tder & ~d;
      'h190: m_rxa  = d & 32'hC0000000;
      'h191: m_rxd  = d & 32'hC0000000;
      'h192: m_reob = m_reob & ~d;
      'h193: m_rder = m_rder & ~d;
      default: ;
    endcase
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cfg = 32'h0007C000; m_esr = 0; m_ier = 0; m_txa = 0; m_txd = 0;
      m_rxa = 0; m_rxd = 0; m_teob = 0; m_tder = 0; m_reob = 0; m_rder = 0;
      m_rdata = 0;
      for (int i = 0; i < NTX; i++) m_txp[i] = 0;
      for (int i = 0; i < NRX; i++) begin m_rxp[i] = 0; m_rsz[i] = 0; end
    end else begin
      if (bus_rd) m_rdata = m_read(int'(bus_addr));
      if (bus_wr) m_write(int'(bus_addr), bus_wdata);
      m_esr  = m_esr  | esr_set_i;
      m_teob = m_teob | 32'(tx_eob_set_i);
      m_tder = m_tder | 32'(tx_derr_set_i);
      m_reob = m_reob | 32'(rx_eob_set_i);
      m_rder = m_rder | 32'(rx_derr_set_i);
    end
  end

  task automatic cmp(input string what, input logic [1023:0] got, input logic [1023:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%0h exp=%0h", what, got, exp);
    end
  endtask

  // per-cycle comparison against the reference, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      logic [NTX*32-1:0] etp;
      logic [NRX*32-1:0] erp;
      logic [NRX*8-1:0]  ers;
      for (int i = 0; i < NTX; i++) etp[i*32 +: 32] = m_txp[i];
      for (int i = 0; i < NRX; i++) begin
        erp[i*32 +: 32] = m_rxp[i];
        ers[i*8 +: 8] = m_rsz[i][7:0];
      end
      cmp("model rdata", 1024'(bus_rdata), 1024'(m_rdata));
      cmp("model cfg", 1024'(cfg_o), 1024'(m_cfg));
      cmp("model esr", 1024'(esr_o), 1024'(m_esr));
      cmp("model ier", 1024'(ier_o), 1024'(m_ier));
      cmp("model txa", 1024'(tx_act_set_o), 1024'(m_txa));
      cmp("model txd", 1024'(tx_act_rst_o), 1024'(m_txd));
      cmp("model rxa", 1024'(rx_act_set_o), 1024'(m_rxa));
      cmp("model rxd", 1024'(rx_act_rst_o), 1024'(m_rxd));
      cmp("model teob", 1024'(tx_eob_o), 1024'(m_teob));
      cmp("model tder", 1024'(tx_derr_o), 1024'(m_tder));
      cmp("model reob", 1024'(rx_eob_o), 1024'(m_reob));
      cmp("model rder", 1024'(rx_derr_o), 1024'(m_rder));
      cmp("model txp", 1024'(tx_desc_ptr_o), 1024'(etp));
      cmp("model rxp", 1024'(rx_desc_ptr_o), 1024'(erp));
      cmp("model rsz", 1024'(rx_buf_size_o), 1024'(ers));
    end
  end

  // ---- stimulus helpers ----
  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [9:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0;
    cmp($sformatf("%s read %0h", tag, a), 1024'(bus_rdata), 1024'(exp));
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    @(negedge clk);
    cmp("R1 cfg reset", 1024'(cfg_o), 1024'(32'h0007C000));
    cmp("R1 rdata reset", 1024'(bus_rdata), 1024'(0));
    rd_chk(10'h180, 32'h0007C000, "R1");
    rd_chk(10'h181, 32'h0, "R1");
    // R2 cfg mask
    wr(10'h180, 32'h7FFFFFFF);
    rd_chk(10'h180, 32'h00FFC087, "R2");
    // R4 masks
    wr(10'h182, 32'hFFFFFFFF);  rd_chk(10'h182, 32'h1F, "R4");
    wr(10'h184, 32'hFFFFFFFF);  rd_chk(10'h184, 32'hF0000000, "R4");
    wr(10'h185, 32'h12345678);  rd_chk(10'h185, 32'h10000000, "R4");
    wr(10'h190, 32'hFFFFFFFF);  rd_chk(10'h190, 32'hC0000000, "R4");
    wr(10'h191, 32'h7FFFFFFF);  rd_chk(10'h191, 32'h40000000, "R4");
    // R7 windows
    wr(10'h1A3, 32'hDEADBEEF);  rd_chk(10'h1A3, 32'hDEADBEEF, "R7");
    wr(10'h1C1, 32'hCAFEF00D);  rd_chk(10'h1C1, 32'hCAFEF00D, "R7");
    wr(10'h1E1, 32'h1234ABCD);  rd_chk(10'h1E1, 32'hCD, "R7");
    // R8 beyond channel counts
    wr(10'h1A4, 32'h11111111);  rd_chk(10'h1A4, 32'h0, "R8");
    wr(10'h1E2, 32'h22222222);  rd_chk(10'h1E2, 32'h0, "R8");
    cmp("R8 rx sizes untouched", 1024'(rx_buf_size_o), 1024'(16'hCD00));
    // R9 undecoded
    rd_chk(10'h183, 32'h0, "R9");
    rd_chk(10'h000, 32'h0, "R9");
    // R6 set pulses
    @(negedge clk);
    tx_eob_set_i = 4'b1011; rx_derr_set_i = 2'b10; esr_set_i = 32'h80000001;
    @(negedge clk);
    tx_eob_set_i = '0; rx_derr_set_i = '0; esr_set_i = '0;
    rd_chk(10'h186, 32'hB, "R6");
    // R5 acknowledge
    wr(10'h186, 32'h1);  rd_chk(10'h186, 32'hA, "R5");
    wr(10'h181, 32'h1);  rd_chk(10'h181, 32'h80000000, "R5");
    // R6 set beats clear in the same cycle
    @(negedge clk);
    bus_addr = 10'h186; bus_wdata = 32'h2; bus_wr = 1'b1; tx_eob_set_i = 4'b0010;
    @(negedge clk);
    bus_wr = 1'b0; tx_eob_set_i = '0;
    rd_chk(10'h186, 32'hA, "R6");
    rd_chk(10'h193, 32'h2, "R6");
    // R3 reinitialisation, with a set pulse alongside (R6)
    @(negedge clk);
    bus_addr = 10'h180; bus_wdata = 32'h80000005; bus_wr = 1'b1; rx_eob_set_i = 2'b01;
    @(negedge clk);
    bus_wr = 1'b0; rx_eob_set_i = '0;
    rd_chk(10'h180, 32'h5, "R3");
    rd_chk(10'h182, 32'h0, "R3");
    rd_chk(10'h181, 32'h0, "R3");
    rd_chk(10'h184, 32'h0, "R3");
    rd_chk(10'h186, 32'h0, "R3");
    rd_chk(10'h193, 32'h0, "R3");
    rd_chk(10'h192, 32'h1, "R6");
    rd_chk(10'h1A3, 32'hDEADBEEF, "R3");
    rd_chk(10'h185, 32'h10000000, "R3");
    // R10 hold between strobes
    wr(10'h182, 32'h3);
    repeat (3) @(negedge clk);
    cmp("R10 rdata held", 1024'(bus_rdata), 1024'(32'h10000000));
    rd_chk(10'h182, 32'h3, "R10");
    repeat (2) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule